// File: doc/BRIEF.md
# Mailbox-Driven I2C Bus Master

This block is an I2C bus master that software drives through six 16-bit registers. Software puts up to two outgoing bytes in a data mailbox and then writes a command word. That command write starts one short bus transaction, which runs in this order:

1. A START condition, or a repeated START.
2. The 7-bit target address followed by the direction bit.
3. One or two data bytes, sent or received.

When the bytes are done, the block either issues a STOP or keeps the bus so that the next command can follow on directly. Longer transfers are built by software as a chain of held commands. There is no FIFO.

Each outcome sets a flag in a status register. There are three flags: write finished, read finished, and error. Software clears a flag by writing a one to it. A level interrupt output is the OR of the flags that are enabled. The SCL and SDA outputs are open-drain enables: a 1 pulls the line low. A fixed divider sets the bus rate. Each SCL period takes four divider ticks. Clock stretching and arbitration are not handled.

Top module: `mbox_i2c_master`

## Requirements
- R1: After reset, the status, enable and read-data registers read 0, both bus lines are released (scl_oe=0, sda_oe=0), and irq is low.
- R2: The status register at offset 0x00 has three flags: bit 13 is error, bit 14 is write finished, bit 15 is read finished. Writing 1 to a flag clears it. Writing 0 leaves it unchanged.
- R3: Writing a command word to offset 0x06 with bits 15:14 = 2 starts a transaction. The transaction sends START, then command bits 7:1 as the address, then the bus direction bit. The bus direction bit is 1 for a read. In the command, bit 10 = 1 means write and bit 10 = 0 means read. A write with no error sets bit 14.
- R4: For a write, the bytes come from the data mailbox at offset 0x04. Bits 7:0 are sent first. Bits 15:8 are sent second, and only when command bit 11 (two bytes) is 1.
- R5: For a read, the first received byte goes into bits 7:0 of offset 0x08 and the second into bits 15:8. Status bit 15 is set when the read completes.
- R6: During a read, the master ACKs every received byte except the last byte of the command, which it NACKs.
- R7: irq is high exactly when some status flag is set and the same bit is set in the enable register at offset 0x02.
- R8: When command bit 13 (hold) is 1 and the transaction succeeds, no STOP is sent. The bus is held with SCL low and SDA released, and the next command begins with a repeated START.
- R9: A NACK on the address byte or on any written data byte sets status bit 13 and does not set bit 14 or bit 15. The transaction ends with a STOP and both lines released, even when hold is set.
- R10: A command written while a transaction is running is ignored.
- R11: A command word whose bits 15:14 are not 2 is ignored and starts no bus activity.
- R12: Offset 0x0A reads back the last accepted command word. Offset 0x06 reads the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Level interrupt request |

## Verification
Each fault shows at the ports as soon as its bus or register effect occurs:

- **Phase or bit counter fault:** a byte goes out in the wrong order or is shifted. The test target's byte log shows this within the first transaction after the fault.
- **ACK decision or byte index fault:** the wrong status flag is set, or received bytes land in the wrong half of the read mailbox. This is visible when the completion flag arrives, a few hundred cycles after the command.
- **Hold flag fault:** a STOP appears where none should, or the repeated START is missing. This is visible on the following command.
- **Busy or command-gating fault:** a second transaction starts. The count of START conditions exposes it.

// File: rtl/mbox_i2c_pkg.sv
package mbox_i2c_pkg;

    // register byte offsets
    localparam logic [3:0] OFS_STAT  = 4'h0;
    localparam logic [3:0] OFS_IEN   = 4'h2;
    localparam logic [3:0] OFS_WDAT  = 4'h4;
    localparam logic [3:0] OFS_CMD   = 4'h6;
    localparam logic [3:0] OFS_RDAT  = 4'h8;
    localparam logic [3:0] OFS_CMDRB = 4'hA;

    // command word fields
    localparam int CB_DIR  = 10;
    localparam int CB_TWO  = 11;
    localparam int CB_HOLD = 13;
    localparam logic [1:0] MODE_NATIVE = 2'b10;

    typedef struct packed {
        logic [6:0] addr;
        logic       wr;
        logic       two;
        logic       hold;
    } cmd_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_START,
        ENG_BIT,
        ENG_STOP
    } eng_e;

    function automatic logic is_native(input logic [1:0] mode);
        return mode == MODE_NATIVE;
    endfunction

    // first byte on the bus: address then direction (1 = read)
    function automatic logic [7:0] frame_byte(input logic [6:0] a, input logic wr);
        return {a, ~wr};
    endfunction

endpackage

// File: rtl/mbox_i2c_clkdiv.sv
module mbox_i2c_clkdiv #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = en;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !en)
                    cnt <= '0;
                else if (cnt == LAST)
                    cnt <= '0;
                else
                    cnt <= cnt + 1'b1;
            end

            assign tick = en && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/mbox_i2c_engine.sv
module mbox_i2c_engine
    import mbox_i2c_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        start,
    input  cmd_t        cmd_i,
    input  logic [15:0] wdata_i,
    input  logic        sda_i,
    output logic        busy,
    output logic        done,
    output logic        done_err,
    output logic        done_read,
    output logic [15:0] rx_data,
    output logic        scl_low,
    output logic        sda_low
);
    eng_e        state;
    logic [1:0]  phase;
    logic [3:0]  bitn;
    logic [1:0]  bytn;
    logic [7:0]  shreg;
    cmd_t        cmd_q;
    logic [15:0] wbuf;
    logic        ack_ok;
    logic        err_q;

    logic ack_slot, tx_mode, last_byte;
    assign ack_slot  = (bitn == 4'd8);
    assign tx_mode   = (bytn == 2'd0) || cmd_q.wr;
    assign last_byte = (bytn == (cmd_q.two ? 2'd2 : 2'd1));
    assign busy      = (state != ENG_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ENG_IDLE;
            phase     <= '0;
            bitn      <= '0;
            bytn      <= '0;
            shreg     <= '0;
            cmd_q     <= '0;
            wbuf      <= '0;
            ack_ok    <= 1'b0;
            err_q     <= 1'b0;
            done      <= 1'b0;
            done_err  <= 1'b0;
            done_read <= 1'b0;
            rx_data   <= '0;
            scl_low   <= 1'b0;
            sda_low   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        cmd_q <= cmd_i;
                        wbuf  <= wdata_i;
                        err_q <= 1'b0;
                        phase <= '0;
                        state <= ENG_START;
                    end
                end
                // same four steps serve a fresh and a repeated START
                ENG_START: if (tick) begin
                    phase <= phase + 2'd1;
                    case (phase)
                        2'd0: sda_low <= 1'b0;
                        2'd1: scl_low <= 1'b0;
                        2'd2: sda_low <= 1'b1;
                        default: begin
                            scl_low <= 1'b1;
                            bitn    <= '0;
                            bytn    <= '0;
                            shreg   <= frame_byte(cmd_q.addr, cmd_q.wr);
                            state   <= ENG_BIT;
                        end
                    endcase
                end
                ENG_BIT: if (tick) begin
                    phase <= phase + 2'd1;
                    case (phase)
                        2'd0: begin
                            if (!ack_slot)
                                sda_low <= tx_mode & ~shreg[7];
                            else
                                sda_low <= !tx_mode && !last_byte;
                        end
                        2'd1: scl_low <= 1'b0;
                        2'd2: begin
                            if (!ack_slot)
                                shreg <= {shreg[6:0], sda_i};
                            else
                                ack_ok <= !sda_i;
                        end
                        default: begin
                            scl_low <= 1'b1;
                            if (!ack_slot) begin
                                bitn <= bitn + 4'd1;
                            end else if (tx_mode && !ack_ok) begin
                                err_q <= 1'b1;
                                state <= ENG_STOP;
                            end else begin
                                if (!tx_mode) begin
                                    if (bytn == 2'd1)
                                        rx_data[7:0] <= shreg;
                                    else
                                        rx_data[15:8] <= shreg;
                                end
                                if (last_byte) begin
                                    if (cmd_q.hold) begin
                                        state     <= ENG_IDLE;
                                        done      <= 1'b1;
                                        done_err  <= 1'b0;
                                        done_read <= !cmd_q.wr;
                                    end else begin
                                        state <= ENG_STOP;
                                    end
                                end else begin
                                    bytn  <= bytn + 2'd1;
                                    bitn  <= '0;
                                    shreg <= (bytn == 2'd0) ? wbuf[7:0] : wbuf[15:8];
                                end
                            end
                        end
                    endcase
                end
                ENG_STOP: if (tick) begin
                    phase <= phase + 2'd1;
                    case (phase)
                        2'd0: sda_low <= 1'b1;
                        2'd1: scl_low <= 1'b0;
                        2'd2: sda_low <= 1'b0;
                        default: begin
                            state     <= ENG_IDLE;
                            done      <= 1'b1;
                            done_err  <= err_q;
                            done_read <= !cmd_q.wr;
                        end
                    endcase
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mbox_i2c_regs.sv
module mbox_i2c_regs
    import mbox_i2c_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  addr,
    input  logic [15:0] wdata,
    input  logic        busy,
    input  logic        done,
    input  logic        done_err,
    input  logic        done_read,
    input  logic [15:0] rx_data,
    output logic [15:0] rdata,
    output logic        start,
    output cmd_t        cmd_o,
    output logic [15:0] wmbox_o,
    output logic        irq
);
    // flag order inside stat/ien: [0]=error, [1]=write done, [2]=read done
    logic [2:0]  stat, ien;
    logic [15:0] wmbox, cmdrb;
    logic [2:0]  set_v, clr_v;

    assign start = wr_en && (addr == OFS_CMD) && is_native(wdata[15:14]) && !busy;
    assign cmd_o = '{addr: wdata[7:1], wr: wdata[CB_DIR], two: wdata[CB_TWO], hold: wdata[CB_HOLD]};

    always_comb begin
        set_v = 3'b000;
        if (done) begin
            if (done_err)       set_v = 3'b001;
            else if (done_read) set_v = 3'b100;
            else                set_v = 3'b010;
        end
        clr_v = (wr_en && addr == OFS_STAT) ? wdata[15:13] : 3'b000;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat  <= '0;
            ien   <= '0;
            wmbox <= '0;
            cmdrb <= '0;
        end else begin
            stat <= (stat & ~clr_v) | set_v;
            if (wr_en && addr == OFS_IEN)  ien   <= wdata[15:13];
            if (wr_en && addr == OFS_WDAT) wmbox <= wdata;
            if (start)                     cmdrb <= wdata;
        end
    end

    assign wmbox_o = wmbox;
    assign irq     = |(stat & ien);

    always_comb begin
        case (addr)
            OFS_STAT:           rdata = {stat, 13'd0};
            OFS_IEN:            rdata = {ien, 13'd0};
            OFS_WDAT:           rdata = wmbox;
            OFS_CMD, OFS_CMDRB: rdata = cmdrb;
            OFS_RDAT:           rdata = rx_data;
            default:            rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbox_i2c_master.sv
module mbox_i2c_master
    import mbox_i2c_pkg::*;
#(
    parameter int DIV = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe,
    output logic        irq
);
    logic        busy, start, tick;
    logic        eng_done, eng_err, eng_read;
    logic [15:0] rx_data, wmbox;
    cmd_t        cmd;

    mbox_i2c_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .done(eng_done), .done_err(eng_err), .done_read(eng_read),
        .rx_data(rx_data), .rdata(reg_rdata), .start(start), .cmd_o(cmd),
        .wmbox_o(wmbox), .irq(irq)
    );

    mbox_i2c_clkdiv #(.DIV(DIV)) u_div (
        .clk(clk), .rst(rst), .en(busy), .tick(tick)
    );

    mbox_i2c_engine u_eng (
        .clk(clk), .rst(rst), .tick(tick), .start(start), .cmd_i(cmd),
        .wdata_i(wmbox), .sda_i(sda_i), .busy(busy), .done(eng_done),
        .done_err(eng_err), .done_read(eng_read), .rx_data(rx_data),
        .scl_low(scl_oe), .sda_low(sda_oe)
    );
endmodule

// File: rtl/mbox_i2c_chk.sv
module mbox_i2c_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic start,
    input logic eng_done,
    input logic eng_err,
    input logic reg_wr,
    input logic scl_oe,
    input logic sda_oe,
    input logic irq
);
    // R9
    bus_freed_on_err_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_done && eng_err) |-> (!scl_oe && !sda_oe));

    // R3
    launch_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R7
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(eng_done || reg_wr));

    // R8
    held_bus_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && scl_oe) |-> !sda_oe);

    // R11
    idle_sda_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> $stable(sda_oe));
endmodule

bind mbox_i2c_master mbox_i2c_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .start(start), .eng_done(eng_done),
    .eng_err(eng_err), .reg_wr(reg_wr), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
);

// File: tb/mbox_i2c_master_tb.sv
module mbox_i2c_master_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        scl_oe, sda_oe, irq;
    logic        slv_low = 1'b0;
    logic        scl_w, sda_w;

    assign scl_w = ~scl_oe;
    assign sda_w = ~(sda_oe | slv_low);

    always #4 clk = ~clk;

    mbox_i2c_master u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_i(sda_w),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
    );

    int ncmp = 0, nbad = 0;

    // ---------------- target model, address 0x50 ----------------
    int nstart = 0, nstop = 0, bitcnt = 0, wcnt = 0, tptr = 0, mcnt = 0;
    int nack_at = -1, wbyte = 0;
    bit fresh = 0, inaddr = 0, rw = 0, ackbit = 0, active = 0;
    logic [7:0] sh = 0, txb = 0;
    logic [7:0] wlog [16];
    logic [7:0] tmem [4];
    bit mlog [8];

    always @(negedge sda_w) if (scl_w === 1'b1) begin
        nstart++; active = 1; fresh = 1; inaddr = 1; bitcnt = 0; slv_low = 0;
    end
    always @(posedge sda_w) if (scl_w === 1'b1) begin
        nstop++; active = 0; slv_low = 0;
    end
    always @(posedge scl_w) if (active) begin
        if (bitcnt < 8) sh = {sh[6:0], sda_w};
        else begin
            ackbit = !sda_w;
            if (!inaddr && rw) begin mlog[mcnt] = !sda_w; mcnt++; end
        end
    end
    always @(negedge scl_w) if (active) begin
        if (fresh) fresh = 0;
        else if (bitcnt == 8) begin
            bitcnt = 0; inaddr = 0;
            if (!ackbit) begin active = 0; slv_low = 0; end
            else if (rw) begin txb = tmem[tptr]; tptr++; slv_low = !txb[7]; end
            else slv_low = 0;
        end else begin
            bitcnt++;
            if (bitcnt == 8) begin
                if (inaddr) begin rw = sh[0]; slv_low = (sh[7:1] == 7'h50); wbyte = 0; end
                else if (!rw) begin
                    wlog[wcnt] = sh; wcnt++;
                    slv_low = (wbyte != nack_at); wbyte++;
                end else slv_low = 0;
            end else if (!inaddr && rw) slv_low = !txb[7-bitcnt];
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        ncmp++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_flag(output logic [15:0] s);
        int n = 0;
        s = 0;
        while ((s & 16'hE000) == 0 && n < 20000) begin rd(4'h0, s); n++; end
        repeat (4) @(negedge clk);
        rd(4'h0, s);
    endtask

    function automatic logic [15:0] mkcmd(input logic [6:0] a, input bit w, input bit two, input bit hold);
        return 16'h8000 | (16'(w) << 10) | (16'(two) << 11) | (16'(hold) << 13) | (16'(a) << 1);
    endfunction

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        logic [15:0] v;
        rd(4'h0, v); chk("R1 status", v, 0);
        rd(4'h2, v); chk("R1 enable", v, 0);
        rd(4'h8, v); chk("R1 rdmbox", v, 0);
        chk("R1 lines", {scl_oe, sda_oe, irq}, 0);
    endtask

    task automatic t_write2;
        logic [15:0] s; int w0 = wcnt, s0 = nstart, p0 = nstop;
        wr(4'h4, 16'hA55A);
        wr(4'h6, mkcmd(7'h50, 1, 1, 0));
        wait_flag(s);
        chk("R3 wdone flag", s, 16'h4000);
        chk("R4 count", wcnt - w0, 2);
        chk("R4 first byte", wlog[w0], 8'h5A);
        chk("R4 second byte", wlog[w0+1], 8'hA5);
        chk("R3 one start/stop", {nstart - s0, nstop - p0}, {32'd1, 32'd1});
        chk("R3 released", {scl_oe, sda_oe}, 0);
        rd(4'hA, s); chk("R12 readback", s, mkcmd(7'h50, 1, 1, 0));
    endtask

    task automatic t_w1c;
        logic [15:0] s;
        wr(4'h0, 16'h0);    rd(4'h0, s); chk("R2 zero keeps", s, 16'h4000);
        wr(4'h0, 16'hA000); rd(4'h0, s); chk("R2 other bits keep", s, 16'h4000);
        wr(4'h0, 16'h4000); rd(4'h0, s); chk("R2 clear", s, 0);
    endtask

    task automatic t_write1_irq;
        logic [15:0] s; int w0 = wcnt;
        wr(4'h4, 16'h77C3);
        wr(4'h6, mkcmd(7'h50, 1, 0, 0));
        wait_flag(s);
        chk("R4 single count", wcnt - w0, 1);
        chk("R4 single byte", wlog[w0], 8'hC3);
        chk("R7 irq masked", irq, 0);
        wr(4'h2, 16'h4000); chk("R7 irq on", irq, 1);
        wr(4'h2, 16'h8000); chk("R7 irq other mask", irq, 0);
        wr(4'h2, 16'h4000); wr(4'h0, 16'h4000); chk("R7 irq after clear", irq, 0);
        wr(4'h2, 16'h0);
    endtask

    task automatic t_read(input bit two, input logic [7:0] b0, input logic [7:0] b1);
        logic [15:0] s; int m0 = mcnt;
        tmem[0] = b0; tmem[1] = b1; tptr = 0;
        wr(4'h6, mkcmd(7'h50, 0, two, 0));
        wait_flag(s);
        chk("R5 rdone flag", s, 16'h8000);
        rd(4'h8, s);
        if (two) begin
            chk("R5 two bytes", s, {b1, b0});
            chk("R6 ack then nack", {mlog[m0], mlog[m0+1]}, 2'b10);
        end else begin
            chk("R5 one byte", s[7:0], b0);
            chk("R6 last nack", mlog[m0], 0);
        end
        wr(4'h0, 16'hE000);
    endtask

    task automatic t_hold;
        logic [15:0] s; int s0 = nstart, p0 = nstop;
        wr(4'h4, 16'h0042);
        wr(4'h6, mkcmd(7'h50, 1, 0, 1));
        wait_flag(s);
        chk("R8 hold wdone", s, 16'h4000);
        chk("R8 no stop", nstop - p0, 0);
        chk("R8 bus held", {scl_oe, sda_oe}, 2'b10);
        wr(4'h0, 16'hE000);
        tmem[0] = 8'h5D; tptr = 0;
        wr(4'h6, mkcmd(7'h50, 0, 0, 0));
        wait_flag(s);
        chk("R8 restart read flag", s, 16'h8000);
        chk("R8 starts/stops", {nstart - s0, nstop - p0}, {32'd2, 32'd1});
        rd(4'h8, s); chk("R8 read after restart", s[7:0], 8'h5D);
        wr(4'h0, 16'hE000);
    endtask

    task automatic t_nack_addr;
        logic [15:0] s; int p0 = nstop;
        wr(4'h6, mkcmd(7'h21, 1, 1, 1));
        wait_flag(s);
        chk("R9 addr nack flag", s, 16'h2000);
        chk("R9 stop despite hold", nstop - p0, 1);
        chk("R9 released", {scl_oe, sda_oe}, 0);
        wr(4'h0, 16'hE000);
    endtask

    task automatic t_nack_data;
        logic [15:0] s;
        nack_at = 1;
        wr(4'h4, 16'h1234);
        wr(4'h6, mkcmd(7'h50, 1, 1, 0));
        wait_flag(s);
        chk("R9 data nack flag", s, 16'h2000);
        chk("R9 released data", {scl_oe, sda_oe}, 0);
        nack_at = -1;
        wr(4'h0, 16'hE000);
    endtask

    task automatic t_busy;
        logic [15:0] s; int s0 = nstart;
        wr(4'h4, 16'h0011);
        wr(4'h6, mkcmd(7'h50, 1, 0, 0));
        wr(4'h6, mkcmd(7'h50, 0, 1, 0));
        wait_flag(s);
        chk("R10 only write done", s, 16'h4000);
        chk("R10 single start", nstart - s0, 1);
        rd(4'hA, s); chk("R12 first kept", s, mkcmd(7'h50, 1, 0, 0));
        wr(4'h0, 16'hE000);
    endtask

    task automatic t_nonnative;
        logic [15:0] s; int s0 = nstart;
        wr(4'h6, 16'h40A1 | 16'h0400);
        repeat (600) @(negedge clk);
        chk("R11 no start", nstart - s0, 0);
        chk("R11 lines idle", {scl_oe, sda_oe}, 0);
        rd(4'h0, s); chk("R11 no flag", s, 0);
        rd(4'h6, s); chk("R12 unchanged", s, mkcmd(7'h50, 1, 0, 0));
    endtask

    initial begin
        #(8 * 190000);
        nbad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        nstart = 0; nstop = 0;
        @(negedge clk);
        t_reset();
        t_write2();
        t_w1c();
        t_write1_irq();
        t_read(0, 8'h3C, 8'h00);
        t_read(1, 8'h81, 8'h7E);
        t_hold();
        t_nack_addr();
        t_nack_data();
        t_busy();
        t_nonnative();
        summary();
        $finish;
    end
endmodule